// File: doc/BRIEF.md
# Paged Instruction-Address Sequencer

This block produces the program-memory fetch address for a small 8-bit core with 2048 words of program store. It holds an 11-bit program counter and a 3-bit page field. Each cycle it takes at most one address event from the decoder and loads the counter from the matching source. The events are: plain advance, taken skip, absolute jump, subroutine call, computed jump (load or add on the low byte), return, return with page restore, interrupt entry and return from interrupt. Jumps and calls take their upper address bits from the page field, so software sets the page before it leaves the current region.

Calls keep their return addresses on an 8-entry hardware stack. Interrupts do not use that stack. Entering an interrupt sends the counter to address 000h and copies four values into a single-level shadow set: the interrupted address, the working register, the status byte (which carries the page field in its top three bits) and the file-select register. Returning from the interrupt brings the address and the page back, and presents the other three values with a restore strobe so the surrounding core can reload its own registers. A registered discard flag marks the fetch that follows any change of flow, which is how a taken skip costs two cycles.

Top module: `pc_sequencer`

## Requirements
- R1: After a synchronous active-low reset, pc_o is 7FFh, page_o is 0 and kill_o is 0.
- R2: An advance with no other event adds one to pc_o at the next edge, and 7FFh wraps to 000h.
- R3: A taken skip adds two to pc_o at the next edge.
- R4: A jump loads pc_o with {page_o[1:0], 9-bit operand}; page bit 2 has no effect on the target.
- R5: A call loads pc_o with {page_o[1:0], 0, 8-bit operand}, so bit 8 is forced to zero, and pushes pc_o+1 onto the return stack.
- R6: A page write replaces page_o and leaves pc_o unchanged. A jump or call in the same cycle uses the page value from before the write.
- R7: A computed jump replaces pc_o[7:0] (write mode) or adds the operand to pc_o[7:0] modulo 256 (add mode). Bits 10:8 stay unchanged.
- R8: A return loads pc_o with the top of the stack and pops it. A page-restoring return also sets page_o to {0, popped[10:9]}.
- R9: The stack holds 8 entries. A push onto a full stack drops the oldest entry. A pop from an empty stack returns the last bottom value again.
- R10: An interrupt sets pc_o to 000h and saves pc_o, w_i, fsr_i and {page_o, status_i[4:0]} into the shadow set. The return stack is left unchanged.
- R11: A return from interrupt restores pc_o and page_o from the shadow set. While reti_i is accepted, ctx_restore_o is 1 and ctx_w_o, ctx_status_o and ctx_fsr_o show the saved values.
- R12: kill_o is 1 in the cycle after any event other than a plain advance or idle, and 0 otherwise.
- R13: When several events are requested at once, the one taken follows this order: interrupt, return from interrupt, return, page-restoring return, call, jump, computed write, computed add, skip, advance. Events that are not taken have no effect on pc_o or the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv_i | input | 1 | Sequential advance |
| skip_i | input | 1 | Taken skip (advance by two) |
| jmp_i | input | 1 | Absolute jump strobe |
| jmp_addr_i | input | 9 | Jump operand |
| call_i | input | 1 | Call strobe |
| call_addr_i | input | 8 | Call operand |
| cj_wr_i | input | 1 | Computed jump, load low byte |
| cj_add_i | input | 1 | Computed jump, add to low byte |
| cj_val_i | input | 8 | Computed jump operand |
| ret_i | input | 1 | Return |
| retp_i | input | 1 | Return with page restore |
| irq_i | input | 1 | Interrupt entry |
| reti_i | input | 1 | Return from interrupt |
| page_wr_i | input | 1 | Page field write strobe |
| page_val_i | input | 3 | New page value |
| w_i | input | 8 | Working register, to be saved |
| status_i | input | 8 | Status byte, to be saved (low five bits) |
| fsr_i | input | 8 | File-select register, to be saved |
| pc_o | output | 11 | Current program counter |
| page_o | output | 3 | Current page field |
| kill_o | output | 1 | Discard the current fetch |
| ctx_restore_o | output | 1 | Shadow values are being restored |
| ctx_w_o | output | 8 | Saved working register |
| ctx_status_o | output | 8 | Saved status byte |
| ctx_fsr_o | output | 8 | Saved file-select register |

## Verification
Two pairs of functions can fall in the same cycle. The first is a page write together with a jump. The bench raises both strobes on one edge and expects the jump target to carry the old page bits while page_o takes the new value. The second is an interrupt arriving in the same cycle as a call. That collision is judged later: after the return from interrupt, a plain return must pop the address pushed before the interrupt and not one the dropped call would have pushed.

// File: rtl/pcseq_pkg.sv
// Package: shared types for the instruction-address sequencer.
// Assumes: exactly one selection is made per cycle by the arbiter.
package pcseq_pkg;

    // Source chosen for the next program counter value
    typedef enum logic [3:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_SKIP,
        SEL_JMP,
        SEL_CALL,
        SEL_CJW,
        SEL_CJA,
        SEL_RET,
        SEL_RETP,
        SEL_IRQ,
        SEL_RETI
    } pc_sel_e;

endpackage

// File: rtl/pcseq_arbiter.sv
// Module: pcseq_arbiter
// Reduces the event strobes to one selection using a fixed priority.
// Assumes: strobes are single-cycle requests; unselected ones are dropped.
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic    adv_i,
    input  logic    skip_i,
    input  logic    jmp_i,
    input  logic    call_i,
    input  logic    cj_wr_i,
    input  logic    cj_add_i,
    input  logic    ret_i,
    input  logic    retp_i,
    input  logic    irq_i,
    input  logic    reti_i,
    output pc_sel_e sel_o
);

    // Priority pick: interrupt first, plain advance last
    always_comb begin
        if (irq_i)         sel_o = SEL_IRQ;
        else if (reti_i)   sel_o = SEL_RETI;
        else if (ret_i)    sel_o = SEL_RET;
        else if (retp_i)   sel_o = SEL_RETP;
        else if (call_i)   sel_o = SEL_CALL;
        else if (jmp_i)    sel_o = SEL_JMP;
        else if (cj_wr_i)  sel_o = SEL_CJW;
        else if (cj_add_i) sel_o = SEL_CJA;
        else if (skip_i)   sel_o = SEL_SKIP;
        else if (adv_i)    sel_o = SEL_INC;
        else               sel_o = SEL_HOLD;
    end

endmodule

// File: rtl/pcseq_nextpc.sv
// Module: pcseq_nextpc
// Computes the next program counter value for the chosen source.
// Assumes: PC_W >= 4; the low SEG_W bits form one segment, the top two bits
// come from the page field for jumps and calls.
module pcseq_nextpc
    import pcseq_pkg::*;
#(
    parameter int PC_W   = 11,
    parameter int PAGE_W = 3
) (
    input  pc_sel_e           sel_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PC_W-3:0]   jmp_addr_i,
    input  logic [PC_W-4:0]   call_addr_i,
    input  logic [PC_W-4:0]   cj_val_i,
    input  logic [PC_W-1:0]   pop_addr_i,
    input  logic [PC_W-1:0]   shadow_pc_i,
    output logic [PC_W-1:0]   pc_next_o
);

    localparam int SEG_W  = PC_W - 3;
    localparam int JMP_W  = PC_W - 2;
    localparam int PG_USE = PC_W - JMP_W;

    logic [PG_USE-1:0] pg_hi;
    logic [SEG_W-1:0]  seg_sum;

    // Page bits that feed jump and call targets
    always_comb pg_hi = page_i[PG_USE-1:0];

    // Low-byte sum for computed jumps, wrapping inside the segment
    always_comb seg_sum = pc_i[SEG_W-1:0] + cj_val_i;

    // Next-address multiplexer
    always_comb begin
        unique case (sel_i)
            SEL_INC:  pc_next_o = pc_i + PC_W'(1);
            SEL_SKIP: pc_next_o = pc_i + PC_W'(2);
            SEL_JMP:  pc_next_o = {pg_hi, jmp_addr_i};
            SEL_CALL: pc_next_o = {pg_hi, 1'b0, call_addr_i};
            SEL_CJW:  pc_next_o = {pc_i[PC_W-1:SEG_W], cj_val_i};
            SEL_CJA:  pc_next_o = {pc_i[PC_W-1:SEG_W], seg_sum};
            SEL_RET,
            SEL_RETP: pc_next_o = pop_addr_i;
            SEL_IRQ:  pc_next_o = '0;
            SEL_RETI: pc_next_o = shadow_pc_i;
            default:  pc_next_o = pc_i;
        endcase
    end

endmodule

// File: rtl/pcseq_retstack.sv
// Module: pcseq_retstack
// Shift-register return stack. Entry 0 is the top.
// Assumes: push and pop never coincide. A push drops the deepest entry when
// full; a pop duplicates the deepest entry, so an empty stack keeps
// returning the last bottom value.
module pcseq_retstack #(
    parameter int W     = 11,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o
);

    logic [W-1:0] ent [DEPTH];

    // Top of stack is read combinationally
    always_comb top_o = ent[0];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;

        // Neighbour values for shifting down (push) and up (pop)
        always_comb begin
            from_above = (g == 0) ? din_i : ent[(g == 0) ? 0 : g-1];
            from_below = (g == DEPTH-1) ? ent[g] : ent[(g == DEPTH-1) ? g : g+1];
        end

        // One stack slot: shifts deeper on push, shallower on pop
        always_ff @(posedge clk) begin
            if (!rst_n)      ent[g] <= '0;
            else if (push_i) ent[g] <= from_above;
            else if (pop_i)  ent[g] <= from_below;
        end
    end

endmodule

// File: rtl/pcseq_shadow.sv
// Module: pcseq_shadow
// Single-level interrupt context: saved address, working, status and
// file-select values.
// Assumes: nested interrupts overwrite the saved set.
module pcseq_shadow #(
    parameter int PC_W   = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] fsr_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [DATA_W-1:0] w_o,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] fsr_o
);

    // Capture the context on interrupt entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o     <= '0;
            w_o      <= '0;
            status_o <= '0;
            fsr_o    <= '0;
        end else if (save_i) begin
            pc_o     <= pc_i;
            w_o      <= w_i;
            status_o <= status_i;
            fsr_o    <= fsr_i;
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
// Module: pc_sequencer (top)
// Paged program counter with return stack and interrupt shadow.
// Assumes: event strobes come from the decoder, sampled at the rising edge;
// the page field occupies the top PAGE_W bits of the status byte.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int             PC_W     = 11,
    parameter int             PAGE_W   = 3,
    parameter int             DATA_W   = 8,
    parameter int             DEPTH    = 8,
    parameter logic [PC_W-1:0] RESET_PC = 11'h7FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              skip_i,
    input  logic              jmp_i,
    input  logic [PC_W-3:0]   jmp_addr_i,
    input  logic              call_i,
    input  logic [PC_W-4:0]   call_addr_i,
    input  logic              cj_wr_i,
    input  logic              cj_add_i,
    input  logic [PC_W-4:0]   cj_val_i,
    input  logic              ret_i,
    input  logic              retp_i,
    input  logic              irq_i,
    input  logic              reti_i,
    input  logic              page_wr_i,
    input  logic [PAGE_W-1:0] page_val_i,
    input  logic [DATA_W-1:0] w_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] fsr_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              kill_o,
    output logic              ctx_restore_o,
    output logic [DATA_W-1:0] ctx_w_o,
    output logic [DATA_W-1:0] ctx_status_o,
    output logic [DATA_W-1:0] ctx_fsr_o
);

    localparam int JMP_W  = PC_W - 2;
    localparam int PG_USE = PC_W - JMP_W;
    localparam int LOW_W  = DATA_W - PAGE_W;

    pc_sel_e           sel;
    logic [PC_W-1:0]   pc_next;
    logic [PC_W-1:0]   pop_addr;
    logic [PC_W-1:0]   shadow_pc;
    logic [DATA_W-1:0] status_save;
    logic              do_push;
    logic              do_pop;
    logic              do_save;
    logic              discontinuity;

    pcseq_arbiter u_arb (
        .adv_i    (adv_i),
        .skip_i   (skip_i),
        .jmp_i    (jmp_i),
        .call_i   (call_i),
        .cj_wr_i  (cj_wr_i),
        .cj_add_i (cj_add_i),
        .ret_i    (ret_i),
        .retp_i   (retp_i),
        .irq_i    (irq_i),
        .reti_i   (reti_i),
        .sel_o    (sel)
    );

    pcseq_nextpc #(
        .PC_W   (PC_W),
        .PAGE_W (PAGE_W)
    ) u_next (
        .sel_i       (sel),
        .pc_i        (pc_o),
        .page_i      (page_o),
        .jmp_addr_i  (jmp_addr_i),
        .call_addr_i (call_addr_i),
        .cj_val_i    (cj_val_i),
        .pop_addr_i  (pop_addr),
        .shadow_pc_i (shadow_pc),
        .pc_next_o   (pc_next)
    );

    // Stack and shadow control derived from the selection
    always_comb begin
        do_push       = (sel == SEL_CALL);
        do_pop        = (sel == SEL_RET) || (sel == SEL_RETP);
        do_save       = (sel == SEL_IRQ);
        discontinuity = (sel != SEL_HOLD) && (sel != SEL_INC);
        status_save   = {page_o, status_i[LOW_W-1:0]};
    end

    pcseq_retstack #(
        .W     (PC_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (do_push),
        .pop_i  (do_pop),
        .din_i  (pc_o + PC_W'(1)),
        .top_o  (pop_addr)
    );

    pcseq_shadow #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_i   (do_save),
        .pc_i     (pc_o),
        .w_i      (w_i),
        .status_i (status_save),
        .fsr_i    (fsr_i),
        .pc_o     (shadow_pc),
        .w_o      (ctx_w_o),
        .status_o (ctx_status_o),
        .fsr_o    (ctx_fsr_o)
    );

    // Restore strobe accompanies an accepted return from interrupt
    always_comb ctx_restore_o = (sel == SEL_RETI);

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_o <= RESET_PC;
        else        pc_o <= pc_next;
    end

    // Page field: interrupt return, page-restoring return, then page write
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_o <= '0;
        else if (sel == SEL_RETI)
            page_o <= ctx_status_o[DATA_W-1:LOW_W];
        else if (sel == SEL_RETP)
            page_o <= PAGE_W'(pop_addr[PC_W-1:PC_W-PG_USE]);
        else if (page_wr_i)
            page_o <= page_val_i;
    end

    // Discard flag for the fetch after a change of flow
    always_ff @(posedge clk) begin
        if (!rst_n) kill_o <= 1'b0;
        else        kill_o <= discontinuity;
    end

endmodule

// File: rtl/pc_sequencer_chk.sv
// Module: pc_sequencer_chk
// Port-level properties of the sequencer, attached by bind.
// Assumes: default widths of the top module.
module pc_sequencer_chk #(
    parameter int PC_W   = 11,
    parameter int PAGE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic              skip_i,
    input logic              jmp_i,
    input logic [PC_W-3:0]   jmp_addr_i,
    input logic              call_i,
    input logic              cj_wr_i,
    input logic              cj_add_i,
    input logic              ret_i,
    input logic              retp_i,
    input logic              irq_i,
    input logic              reti_i,
    input logic              page_wr_i,
    input logic [PAGE_W-1:0] page_val_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [PAGE_W-1:0] page_o,
    input logic              kill_o
);

    localparam int PG_USE = 2;
    localparam int SEG_W  = PC_W - 3;

    logic flow_ev;
    logic above_jmp;
    logic above_cj;

    // Request groups used as antecedents
    always_comb begin
        above_jmp = irq_i | reti_i | ret_i | retp_i | call_i;
        above_cj  = above_jmp | jmp_i;
        flow_ev   = skip_i | above_cj | cj_wr_i | cj_add_i;
    end

    // R2
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !flow_ev) |=> (pc_o == PC_W'($past(pc_o) + 1'b1)));

    // R3
    skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_i && !above_cj && !cj_wr_i && !cj_add_i) |=> (pc_o == PC_W'($past(pc_o) + 2'd2)));

    // R4
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_i && !above_jmp) |=> (pc_o == {$past(page_o[PG_USE-1:0]), $past(jmp_addr_i)}));

    // R6
    page_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr_i && !retp_i && !reti_i) |=> (page_o == $past(page_val_i)));

    // R7
    cj_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cj_wr_i || cj_add_i) && !above_cj) |=> (pc_o[PC_W-1:SEG_W] == $past(pc_o[PC_W-1:SEG_W])));

    // R10
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (pc_o == '0));

    // R12
    kill_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flow_ev |=> kill_o);

    // R12
    kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_ev |=> !kill_o);

endmodule

bind pc_sequencer pc_sequencer_chk #(
    .PC_W   (PC_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv_i),
    .skip_i     (skip_i),
    .jmp_i      (jmp_i),
    .jmp_addr_i (jmp_addr_i),
    .call_i     (call_i),
    .cj_wr_i    (cj_wr_i),
    .cj_add_i   (cj_add_i),
    .ret_i      (ret_i),
    .retp_i     (retp_i),
    .irq_i      (irq_i),
    .reti_i     (reti_i),
    .page_wr_i  (page_wr_i),
    .page_val_i (page_val_i),
    .pc_o       (pc_o),
    .page_o     (page_o),
    .kill_o     (kill_o)
);

// File: tb/pc_sequencer_test.sv
// Directed bench for pc_sequencer: one task per scenario, 200 MHz clock.
module pc_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv_i, skip_i, jmp_i, call_i, cj_wr_i, cj_add_i;
    logic        ret_i, retp_i, irq_i, reti_i, page_wr_i;
    logic [8:0]  jmp_addr_i;
    logic [7:0]  call_addr_i, cj_val_i, w_i, status_i, fsr_i;
    logic [2:0]  page_val_i;
    logic [10:0] pc_o;
    logic [2:0]  page_o;
    logic        kill_o, ctx_restore_o;
    logic [7:0]  ctx_w_o, ctx_status_o, ctx_fsr_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pc_sequencer uut (
        .clk (clk), .rst_n (rst_n),
        .adv_i (adv_i), .skip_i (skip_i),
        .jmp_i (jmp_i), .jmp_addr_i (jmp_addr_i),
        .call_i (call_i), .call_addr_i (call_addr_i),
        .cj_wr_i (cj_wr_i), .cj_add_i (cj_add_i), .cj_val_i (cj_val_i),
        .ret_i (ret_i), .retp_i (retp_i), .irq_i (irq_i), .reti_i (reti_i),
        .page_wr_i (page_wr_i), .page_val_i (page_val_i),
        .w_i (w_i), .status_i (status_i), .fsr_i (fsr_i),
        .pc_o (pc_o), .page_o (page_o), .kill_o (kill_o),
        .ctx_restore_o (ctx_restore_o), .ctx_w_o (ctx_w_o),
        .ctx_status_o (ctx_status_o), .ctx_fsr_o (ctx_fsr_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clr();
        {adv_i, skip_i, jmp_i, call_i, cj_wr_i, cj_add_i} = '0;
        {ret_i, retp_i, irq_i, reti_i, page_wr_i} = '0;
    endtask

    // Apply the current strobes on one edge, then clear them
    task automatic step();
        @(posedge clk);
        #1;
        clr();
    endtask

    task automatic t_reset();
        // R1
        chk("R1", "pc", pc_o, 11'h7FF);
        chk("R1", "page", page_o, 3'd0);
        chk("R1", "kill", kill_o, 1'b0);
    endtask

    task automatic t_advance();
        adv_i = 1; step();
        chk("R2", "wrap 7FF", pc_o, 11'h000);
        chk("R12", "no kill after advance", kill_o, 1'b0);
        adv_i = 1; step();
        chk("R2", "increment", pc_o, 11'h001);
    endtask

    task automatic t_skip();
        skip_i = 1; step();
        chk("R3", "skip by two", pc_o, 11'h003);
        chk("R12", "kill after skip", kill_o, 1'b1);
        adv_i = 1; step();
        chk("R3", "advance after skip", pc_o, 11'h004);
        chk("R12", "kill clears", kill_o, 1'b0);
    endtask

    task automatic t_jump();
        page_wr_i = 1; page_val_i = 3'b110; step();
        chk("R6", "page written", page_o, 3'b110);
        chk("R6", "pc unchanged by page write", pc_o, 11'h004);
        jmp_i = 1; jmp_addr_i = 9'h1A5; step();
        chk("R4", "jump target, page bit 2 ignored", pc_o, 11'h5A5);
        chk("R12", "kill after jump", kill_o, 1'b1);
        // same-cycle page write and jump
        page_wr_i = 1; page_val_i = 3'b001; jmp_i = 1; jmp_addr_i = 9'h033; step();
        chk("R6", "jump uses old page", pc_o, 11'h433);
        chk("R6", "page takes new value", page_o, 3'b001);
        jmp_i = 1; jmp_addr_i = 9'h010; step();
        chk("R4", "jump with new page", pc_o, 11'h210);
    endtask

    task automatic t_call_ret();
        call_i = 1; call_addr_i = 8'hF0; step();
        chk("R5", "call target bit8 zero", pc_o, 11'h2F0);
        adv_i = 1; step();
        ret_i = 1; call_i = 1; call_addr_i = 8'h99; step();
        chk("R13", "return beats call", pc_o, 11'h211);
        chk("R8", "page unchanged by ret", page_o, 3'b001);
        page_wr_i = 1; page_val_i = 3'b011; step();
        call_i = 1; call_addr_i = 8'h40; step();
        chk("R5", "call with page 3", pc_o, 11'h640);
        retp_i = 1; step();
        chk("R8", "retp pc", pc_o, 11'h212);
        chk("R8", "retp page", page_o, 3'b001);
    endtask

    task automatic t_computed();
        cj_wr_i = 1; cj_val_i = 8'hFE; skip_i = 1; step();
        chk("R7", "computed write (beats skip R13)", pc_o, 11'h2FE);
        cj_add_i = 1; cj_val_i = 8'h05; step();
        chk("R7", "computed add wraps in segment", pc_o, 11'h203);
        chk("R12", "kill after computed jump", kill_o, 1'b1);
    endtask

    task automatic t_stack();
        page_wr_i = 1; page_val_i = 3'b000; step();
        for (int i = 0; i < 9; i++) begin
            call_i = 1; call_addr_i = 8'h20 + 8'(i); step();
        end
        chk("R5", "last call target", pc_o, 11'h028);
        for (int i = 0; i < 8; i++) begin
            ret_i = 1; step();
            chk("R9", "pop order", pc_o, 11'h028 - 11'(i));
        end
        ret_i = 1; step();
        chk("R9", "pop from empty returns bottom", pc_o, 11'h021);
    endtask

    task automatic t_irq();
        call_i = 1; call_addr_i = 8'h55; step();
        chk("R5", "call before irq", pc_o, 11'h055);
        page_wr_i = 1; page_val_i = 3'b101; step();
        w_i = 8'h3C; status_i = 8'h1B; fsr_i = 8'h9D;
        irq_i = 1; call_i = 1; call_addr_i = 8'h77; step();
        chk("R10", "irq vector", pc_o, 11'h000);
        chk("R12", "kill after irq", kill_o, 1'b1);
        w_i = 8'h00; status_i = 8'h00; fsr_i = 8'h00;
        page_wr_i = 1; page_val_i = 3'b000; step();
        adv_i = 1; step();
        adv_i = 1; step();
        chk("R2", "advance in handler", pc_o, 11'h002);
        reti_i = 1;
        #0.5;
        chk("R11", "restore strobe", ctx_restore_o, 1'b1);
        chk("R11", "saved w", ctx_w_o, 8'h3C);
        chk("R11", "saved status with page", ctx_status_o, 8'hBB);
        chk("R11", "saved fsr", ctx_fsr_o, 8'h9D);
        step();
        chk("R11", "pc restored", pc_o, 11'h055);
        chk("R11", "page restored", page_o, 3'b101);
        chk("R11", "restore strobe drops", ctx_restore_o, 1'b0);
        ret_i = 1; step();
        chk("R10", "stack untouched by irq and dropped call", pc_o, 11'h022);
    endtask

    initial begin
        rst_n = 1'b0;
        clr();
        jmp_addr_i = '0; call_addr_i = '0; cj_val_i = '0; page_val_i = '0;
        w_i = '0; status_i = '0; fsr_i = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_advance();
        t_skip();
        t_jump();
        t_call_ret();
        t_computed();
        t_stack();
        t_irq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (R1-run incomplete): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule